// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Retransmit

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Words go into an inferred RAM from the write clock domain and come out in the read clock domain. The block reports status through an empty/ready flag, a full/ready flag, a half-full flag and two programmable almost-empty and almost-full flags. Each of those two thresholds is either one of eight preset offsets, chosen by a three-bit select sampled during master reset, or a value loaded afterwards through a small write-side configuration port.

A mode input picks the read timing. In standard mode a read request returns data one read clock later. In first-word-fall-through mode the head word is presented without a request. A level-sensitive mark input records the head position on its rising edge and protects the marked region from being overwritten while it stays high. A retransmit pulse issued during that time rewinds the read side to the marked word. A partial reset empties the buffer but keeps loaded thresholds. A master reset also restores the preset thresholds.

Top module: `fifo_mark_rt`

## Requirements
- R1: After master reset the buffer is empty. In standard mode `out_flag`=1 (empty) and `in_flag`=0 (not full). In fall-through mode `out_flag`=0 (no word ready) and `in_flag`=1 (space available). `half_flag`=0, `pae`=1 and `paf`=0.
- R2: In standard mode a read request taken while not empty places the oldest word on `dout` after the next read clock edge, and words leave in write order.
- R3: In fall-through mode the oldest word appears on `dout` with `out_flag`=1 without a request. A request advances to the next word. The displayed word and `out_flag` hold while no request is made.
- R4: Once DEPTH words are held, `in_flag` shows full and further writes are dropped without moving the write pointer.
- R5: A read request while empty in standard mode leaves `dout` and the read position unchanged.
- R6: `half_flag` is 1 exactly when the write-side fill level exceeds DEPTH/2.
- R7: While `mrst_n` is low, both thresholds take min((4 << `ofs_pick`) - 1, DEPTH/2 - 1). `pae`=1 when the read-side level is at most the empty threshold. `paf`=1 when the write-side level is at least DEPTH minus the full threshold.
- R8: A write-clock cycle with `cfg_we`=1 loads `cfg_val` into the full threshold when `cfg_to_full`=1, and into the empty threshold when `cfg_to_full`=0.
- R9: A partial reset empties the buffer and keeps the loaded thresholds. A master reset brings back the preset thresholds.
- R10: The read-clock cycle in which `mark` rises records the head position. A `rexmit` pulse while `mark` is still high makes the next word read the recorded one. `rexmit` with `mark` low is ignored.
- R11: While `mark` is high the write side counts every word from the marked position onward as occupied, so `in_flag` shows full when that span reaches DEPTH. After `mark` falls the space is released.
- R12: With `flag_reg`=1, `pae` and `paf` change one clock of their own domain later than with `flag_reg`=0.
- R13: Pointers cross the clock domains in Gray code, and each synchronized pointer changes in at most one bit per destination clock, including after a mark is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| fwft_en | input | 1 | 1 = fall-through timing, 0 = standard |
| flag_reg | input | 1 | 1 = registered almost flags, 0 = direct |
| ofs_pick | input | 3 | Preset threshold select, sampled in master reset |
| cfg_we | input | 1 | Threshold load strobe (write clock) |
| cfg_to_full | input | 1 | 1 = load full threshold, 0 = empty threshold |
| cfg_val | input | AW | Threshold value |
| wen | input | 1 | Write request |
| din | input | DW | Write data |
| ren | input | 1 | Read request |
| mark | input | 1 | Mark level; rising edge records head |
| rexmit | input | 1 | Retransmit request |
| dout | output | DW | Read data |
| out_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| in_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_flag | output | 1 | More than half full |
| pae | output | 1 | Almost empty |
| paf | output | 1 | Almost full |

## Verification
The checks assume that `fwft_en`, `flag_reg` and `ofs_pick` change only while master reset is asserted. They also assume that `mark` and `rexmit` are driven from the read clock domain and that `rexmit` is raised only after `mark` has been high for at least one edge. The stimulus drives every input on the falling edge of its own clock and changes the mode inputs only inside the reset task. It also waits for the pointer synchronizers and the released mark span to settle before it samples a flag.

// File: rtl/fifo_mark_rt.sv
module fifo_mark_rt #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_en,
  input  logic          flag_reg,
  input  logic [2:0]    ofs_pick,
  input  logic          cfg_we,
  input  logic          cfg_to_full,
  input  logic [AW-1:0] cfg_val,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ren,
  input  logic          mark,
  input  logic          rexmit,
  output logic [DW-1:0] dout,
  output logic          out_flag,
  output logic          in_flag,
  output logic          half_flag,
  output logic          pae,
  output logic          paf
);
  localparam int PW = AW + 1;
  localparam int TW = AW + 10;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] ONE_P   = PW'(1);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] gv);
    logic [PW-1:0] b;
    b[PW-1] = gv[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ gv[i];
    return b;
  endfunction

  function automatic logic [AW-1:0] preset_of(input logic [2:0] s);
    logic [TW-1:0] t;
    t = (TW'(4) << s) - TW'(1);
    if (t > TW'(DEPTH / 2 - 1)) t = TW'(DEPTH / 2 - 1);
    return t[AW-1:0];
  endfunction

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wptr, wgray, rq1, rq2, rref_w, fill_w;
  logic [AW-1:0] pae_ofs, paf_ofs;
  logic          full_w, wr_go, paf_c, paf_q;

  assign rref_w = from_gray(rq2);
  assign fill_w = wptr - rref_w;
  assign full_w = (fill_w == DEPTH_P);
  assign wr_go  = wen & ~full_w;
  assign paf_c  = (fill_w >= DEPTH_P - {1'b0, paf_ofs});

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
      paf_q <= 1'b0;
    end else begin
      rq1   <= rgray;
      rq2   <= rq1;
      paf_q <= paf_c;
      if (wr_go) begin
        wptr  <= wptr + ONE_P;
        wgray <= to_gray(wptr + ONE_P);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      pae_ofs <= preset_of(ofs_pick);
      paf_ofs <= preset_of(ofs_pick);
    end else if (cfg_we && prst_n) begin
      if (cfg_to_full) paf_ofs <= cfg_val;
      else             pae_ofs <= cfg_val;
    end
  end

  // read domain
  logic [PW-1:0] rptr, refp, ref_nx, rgray, wq1, wq2, wsync;
  logic [PW-1:0] mark_ptr, mark_pos, tgt, lvl_r;
  logic          mark_q, ov, empty_r, rt_go, ld, pae_c, pae_q;

  assign wsync    = from_gray(wq2);
  assign empty_r  = (wsync == rptr);
  assign mark_pos = rptr - {{(PW-1){1'b0}}, fwft_en & ov};
  assign lvl_r    = wsync - mark_pos;
  assign rt_go    = rexmit & mark & mark_q;
  assign ld       = ~rt_go & ~empty_r & (fwft_en ? (~ov | ren) : ren);
  assign tgt      = mark_q ? mark_ptr : mark_pos;
  assign ref_nx   = refp + {{(PW-1){1'b0}}, refp != tgt};
  assign pae_c    = (lvl_r <= {1'b0, pae_ofs});

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      refp     <= '0;
      rgray    <= '0;
      wq1      <= '0;
      wq2      <= '0;
      mark_ptr <= '0;
      mark_q   <= 1'b0;
      ov       <= 1'b0;
      pae_q    <= 1'b1;
    end else begin
      wq1    <= wgray;
      wq2    <= wq1;
      mark_q <= mark;
      pae_q  <= pae_c;
      refp   <= ref_nx;
      rgray  <= to_gray(ref_nx);
      if (mark && !mark_q) mark_ptr <= mark_pos;
      if (rt_go) begin
        rptr <= mark_ptr;
        ov   <= 1'b0;
      end else if (ld) begin
        rptr <= rptr + ONE_P;
        ov   <= 1'b1;
      end else if (fwft_en && ren) begin
        ov   <= 1'b0;
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (ld) dout <= mem[rptr[AW-1:0]];
  end

  assign out_flag  = fwft_en ? ov : empty_r;
  assign in_flag   = fwft_en ? ~full_w : full_w;
  assign half_flag = (fill_w > HALF_P);
  assign pae       = flag_reg ? pae_q : pae_c;
  assign paf       = flag_reg ? paf_q : paf_c;
endmodule

module fifo_mark_rt_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter int PW    = 11
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          fwft_en,
  input logic          wen,
  input logic          ren,
  input logic          rexmit,
  input logic          full_w,
  input logic          empty_r,
  input logic          ov,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wq2,
  input logic [PW-1:0] rq2,
  input logic [PW-1:0] fill_w,
  input logic [DW-1:0] dout
);
  // R4
  no_wr_when_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && full_w) |=> $stable(wptr));

  // R5
  no_rd_when_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_en && ren && empty_r && !rexmit) |=> $stable(rptr));

  // R3
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_en && ov && !ren && !rexmit) |=> (ov && $stable(dout)));

  // R11
  fill_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    fill_w <= PW'(DEPTH));

  // R13
  wgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    1'b1 |=> ($countones(wq2 ^ $past(wq2)) <= 1));

  // R13
  rgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> ($countones(rq2 ^ $past(rq2)) <= 1));
endmodule

bind fifo_mark_rt fifo_mark_rt_chk #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) chk_i (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_en(fwft_en), .wen(wen),
  .ren(ren), .rexmit(rexmit), .full_w(full_w), .empty_r(empty_r), .ov(ov),
  .wptr(wptr), .rptr(rptr), .wq2(wq2), .rq2(rq2), .fill_w(fill_w), .dout(dout)
);

// File: tb/fifo_mark_rt_tb.sv
module fifo_mark_rt_tb_top;
  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 1, prst_n = 1, fwft_en = 0, flag_reg = 0;
  logic [2:0] ofs_pick = 3'd1;
  logic cfg_we = 0, cfg_to_full = 0;
  logic [AW-1:0] cfg_val = '0;
  logic wen = 0, ren = 0, mark = 0, rexmit = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic out_flag, in_flag, half_flag, pae, paf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 wclk = ~wclk;
  initial begin #5; forever #10 rclk = ~rclk; end

  fifo_mark_rt #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_en(fwft_en), .flag_reg(flag_reg), .ofs_pick(ofs_pick),
    .cfg_we(cfg_we), .cfg_to_full(cfg_to_full), .cfg_val(cfg_val),
    .wen(wen), .din(din), .ren(ren), .mark(mark), .rexmit(rexmit),
    .dout(dout), .out_flag(out_flag), .in_flag(in_flag),
    .half_flag(half_flag), .pae(pae), .paf(paf));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n = 12);
    repeat (n) @(negedge rclk);
  endtask

  task automatic do_reset(input bit fw, input bit fr, input logic [2:0] sel);
    fwft_en = fw; flag_reg = fr; ofs_pick = sel;
    @(negedge wclk) mrst_n = 0;
    repeat (4) @(negedge wclk);
    mrst_n = 1;
    settle();
  endtask

  task automatic wr(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk) wen = 1; din = DW'(base + i);
    end
    @(negedge wclk) wen = 0;
  endtask

  task automatic rd(input int exp, input string tag);
    @(negedge rclk) ren = 1;
    @(negedge rclk) ren = 0;
    check(tag, int'(dout), exp);
  endtask

  task automatic cfg(input bit to_full, input int v);
    @(negedge wclk) cfg_we = 1; cfg_to_full = to_full; cfg_val = AW'(v);
    @(negedge wclk) cfg_we = 0;
  endtask

  task automatic t_reset;
    do_reset(0, 0, 3'd1);
    check("R1 std empty", out_flag, 1);
    check("R1 std full", in_flag, 0);
    check("R1 half", half_flag, 0);
    check("R1 pae", pae, 1);
    check("R1 paf", paf, 0);
    do_reset(1, 0, 3'd1);
    check("R1 fwft ready", out_flag, 0);
    check("R1 fwft space", in_flag, 1);
  endtask

  task automatic t_order;
    do_reset(0, 0, 3'd1);
    wr(5, 16'hA0);
    settle();
    for (int i = 0; i < 5; i++) rd(16'hA0 + i, "R2 order");
    check("R2 empty after", out_flag, 1);
  endtask

  task automatic t_empty_read;
    do_reset(0, 0, 3'd1);
    wr(1, 16'h77); settle();
    rd(16'h77, "R5 setup");
    rd(16'h77, "R5 empty read keeps dout");
    rd(16'h77, "R5 empty read keeps dout");
    wr(1, 16'h55); settle();
    rd(16'h55, "R5 position unchanged");
  endtask

  task automatic t_full;
    do_reset(0, 0, 3'd1);
    wr(DEPTH + 1, 0);
    settle();
    check("R4 full flag", in_flag, 1);
    for (int i = 0; i < DEPTH; i++) rd(i, "R4 data, dropped write absent");
    check("R4 empty after drain", out_flag, 1);
  endtask

  task automatic t_half;
    do_reset(0, 0, 3'd1);
    wr(DEPTH / 2, 0); settle();
    check("R6 at half", half_flag, 0);
    wr(1, 0); settle();
    check("R6 above half", half_flag, 1);
  endtask

  task automatic t_defaults;
    do_reset(0, 0, 3'd1);
    wr(7, 0); settle();
    check("R7 pae at 7", pae, 1);
    wr(1, 0); settle();
    check("R7 pae at 8", pae, 0);
    wr(48, 0); settle();
    check("R7 paf at 56", paf, 0);
    wr(1, 0); settle();
    check("R7 paf at 57", paf, 1);
    do_reset(0, 0, 3'd2);
    wr(15, 0); settle();
    check("R7 sel2 pae at 15", pae, 1);
    wr(1, 0); settle();
    check("R7 sel2 pae at 16", pae, 0);
  endtask

  task automatic t_load;
    do_reset(0, 0, 3'd1);
    cfg(0, 20);
    cfg(1, 10);
    wr(20, 0); settle();
    check("R8 pae at 20", pae, 1);
    wr(1, 0); settle();
    check("R8 pae at 21", pae, 0);
    wr(32, 0); settle();
    check("R8 paf at 53", paf, 0);
    wr(1, 0); settle();
    check("R8 paf at 54", paf, 1);
    @(negedge wclk) prst_n = 0;
    repeat (3) @(negedge wclk);
    prst_n = 1;
    settle();
    check("R9 partial empties", out_flag, 1);
    check("R9 partial paf clear", paf, 0);
    wr(20, 0); settle();
    check("R9 loaded pae kept", pae, 1);
    do_reset(0, 0, 3'd1);
    wr(8, 0); settle();
    check("R9 master restores preset", pae, 0);
  endtask

  task automatic t_fwft;
    do_reset(1, 0, 3'd1);
    wr(3, 16'h30); settle();
    check("R3 ready without request", out_flag, 1);
    check("R3 head shown", int'(dout), 16'h30);
    rd(16'h31, "R3 advance");
    rd(16'h32, "R3 advance");
    @(negedge rclk) ren = 1;
    @(negedge rclk) ren = 0;
    check("R3 not ready when drained", out_flag, 0);
  endtask

  task automatic t_mark;
    do_reset(0, 0, 3'd1);
    wr(6, 16'h10); settle();
    rd(16'h10, "R10 pre");
    rd(16'h11, "R10 pre");
    @(negedge rclk) mark = 1;
    rd(16'h12, "R10 after mark");
    rd(16'h13, "R10 after mark");
    rd(16'h14, "R10 after mark");
    @(negedge rclk) rexmit = 1;
    @(negedge rclk) rexmit = 0;
    rd(16'h12, "R10 rewind to mark");
    rd(16'h13, "R10 replay");
    @(negedge rclk) mark = 0;
    @(negedge rclk) rexmit = 1;
    @(negedge rclk) rexmit = 0;
    rd(16'h14, "R10 rexmit ignored without mark");
  endtask

  task automatic t_mark_hold;
    do_reset(0, 0, 3'd1);
    @(negedge rclk) mark = 1;
    wr(10, 0); settle();
    for (int i = 0; i < 10; i++) rd(i, "R11 drain");
    wr(DEPTH - 10, 0); settle();
    check("R11 full from marked span", in_flag, 1);
    @(negedge rclk) mark = 0;
    settle(DEPTH + 20);
    check("R11 space released", in_flag, 0);
  endtask

  task automatic t_flagreg(input bit fr);
    do_reset(0, fr, 3'd1);
    wr(9, 0); settle();
    @(negedge rclk) ren = 1;
    @(negedge rclk);
    @(negedge rclk) ren = 0;
    check("R12 pae edge timing", pae, fr ? 0 : 1);
    @(negedge rclk);
    check("R12 pae settled", pae, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_empty_read();
    t_full();
    t_half();
    t_defaults();
    t_load();
    t_fwft();
    t_mark();
    t_mark_hold();
    t_flagreg(0);
    t_flagreg(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule